// File: doc/BRIEF.md
# Carrier Wipe-Off Mixer

This block strips the residual carrier from a complex baseband sample stream. Each I/Q sample that arrives with its valid strobe is multiplied, component by component, with a locally generated carrier. The carrier comes from a small direct digital synthesiser. A phase accumulator advances by a frequency control word once per accepted sample. A separately held phase trim word is added to the accumulated phase. The top bits of that sum select a cosine and a sine value from a coarse table.

The sample clock runs much faster than the sample rate, so samples are strobed and arrive on only some cycles. The tracking loop supplies the frequency word continuously. It updates the phase trim through a load strobe. The products leave the block a fixed two cycles after their samples. They hold their value between valid outputs.

Top module: `cwo_mixer`

## Requirements
- R1: While rst_ni is low, and in the cycles after it rises until the first product, valid_o is 0 and i_o and q_o are 0. Reset clears the phase accumulator and the phase trim, so the first valid sample after reset uses phase 0, which is table index 0.
- R2: valid_o is high exactly two rising clock edges after a rising edge at which valid_i was high, and low otherwise.
- R3: The phase applied to the n-th valid sample after reset (n counted from 0) is n times fcw_i plus the held trim, modulo 2^32. Here fcw_i is summed as it stood at each earlier valid sample. Cycles with valid_i low do not advance the accumulator, whatever fcw_i is.
- R4: The table index is bits [31:29] of the phase. For index k = 0..7 the cosine value is 3, 2, 0, -2, -3, -2, 0, 2, and the sine value is the cosine value of index (k-2) mod 8.
- R5: Samples are two's-complement 3-bit values. i_o equals i_i times the cosine value and q_o equals q_i times the sine value, each a 6-bit two's-complement product whose magnitude never exceeds 12.
- R6: perr_i is stored into the trim register on a rising edge where perr_load_i is high. The new trim applies from the next valid sample after that edge. A valid sample on the same edge as the load still uses the old trim.
- R7: Changes on perr_i while perr_load_i is low have no effect on the products.
- R8: While valid_o is low, i_o and q_o keep the value of the last product.

Top module port order follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Processing clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Sample strobe |
| i_i | input | 3 | In-phase sample, signed |
| q_i | input | 3 | Quadrature sample, signed |
| fcw_i | input | 32 | Frequency control word added per valid sample |
| perr_i | input | 32 | Phase trim value from the tracking loop |
| perr_load_i | input | 1 | Load strobe for the phase trim |
| valid_o | output | 1 | Product strobe, two cycles after valid_i |
| i_o | output | 6 | In-phase product, signed |
| q_o | output | 6 | Quadrature product, signed |

## Verification
The bench steps the frequency word by exactly one table index per sample and walks all eight table entries. A swapped or shifted sine or cosine entry therefore shows up as a wrong product at that index. Gaps in the valid strobe are mixed with changing frequency words, which catches an accumulator that advances on idle cycles. A trim load on the same edge as a sample catches a trim that applies one sample early. Trim values present without a load catch a trim register that is not gated. A most negative sample times the most negative cosine catches a multiplier that sign-extends wrongly. Idle stretches catch outputs that do not hold, and a reset in mid-run catches state that survives reset.

// File: rtl/cwo_pkg.sv
package cwo_pkg;
  localparam int IDX_W = 3;
  localparam int AMP_W = 3;
  typedef logic signed [AMP_W-1:0] amp_t;

  // coarse cosine, amplitude 3
  function automatic amp_t cos_amp(input logic [IDX_W-1:0] k);
    amp_t v;
    case (k)
      3'd0: v = 3'sd3;
      3'd1, 3'd7: v = 3'sd2;
      3'd3, 3'd5: v = -3'sd2;
      3'd4: v = -3'sd3;
      default: v = 3'sd0;
    endcase
    return v;
  endfunction

  // sine is cosine shifted by a quarter turn
  function automatic amp_t sin_amp(input logic [IDX_W-1:0] k);
    return cos_amp(k - IDX_W'(2));
  endfunction
endpackage

// File: rtl/cwo_phase_gen.sv
module cwo_phase_gen #(
  parameter int PHASE_W = 32,
  parameter int IDX_W   = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               step_i,
  input  logic [PHASE_W-1:0] fcw_i,
  input  logic [PHASE_W-1:0] trim_i,
  input  logic               trim_load_i,
  output logic [IDX_W-1:0]   idx_o
);
  logic [PHASE_W-1:0] acc_q, trim_q, phase;

  assign phase = acc_q + trim_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      trim_q <= '0;
      idx_o  <= '0;
    end else begin
      if (step_i) begin
        acc_q <= acc_q + fcw_i;
        idx_o <= phase[PHASE_W-1 -: IDX_W];
      end
      if (trim_load_i) trim_q <= trim_i;
    end
  end
endmodule

// File: rtl/cwo_sincos_lut.sv
module cwo_sincos_lut
  import cwo_pkg::*;
(
  input  logic [IDX_W-1:0] idx_i,
  output amp_t             cos_o,
  output amp_t             sin_o
);
  always_comb begin
    cos_o = cos_amp(idx_i);
    sin_o = sin_amp(idx_i);
  end
endmodule

// File: rtl/cwo_scale.sv
module cwo_scale #(
  parameter int IN_W  = 3,
  parameter int AMP_W = 3,
  localparam int OUT_W = IN_W + AMP_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    en_i,
  input  logic signed [IN_W-1:0]  x_i,
  input  logic signed [AMP_W-1:0] amp_i,
  output logic signed [OUT_W-1:0] y_o
);
  logic signed [OUT_W-1:0] xe, ae, prod;

  always_comb begin
    xe   = OUT_W'(x_i);
    ae   = OUT_W'(amp_i);
    prod = xe * ae;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   y_o <= '0;
    else if (en_i) y_o <= prod;
  end
endmodule

// File: rtl/cwo_mixer.sv
module cwo_mixer
  import cwo_pkg::*;
#(
  parameter int SAMPLE_W = 3,
  parameter int PHASE_W  = 32,
  localparam int OUT_W   = SAMPLE_W + AMP_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                valid_i,
  input  logic [SAMPLE_W-1:0] i_i,
  input  logic [SAMPLE_W-1:0] q_i,
  input  logic [PHASE_W-1:0]  fcw_i,
  input  logic [PHASE_W-1:0]  perr_i,
  input  logic                perr_load_i,
  output logic                valid_o,
  output logic [OUT_W-1:0]    i_o,
  output logic [OUT_W-1:0]    q_o
);
  localparam int NCH = 2;

  logic [IDX_W-1:0]    idx;
  amp_t                cos_v, sin_v;
  logic                v1_q;
  logic [SAMPLE_W-1:0] smp_q [NCH];
  logic [SAMPLE_W-1:0] smp_d [NCH];
  amp_t                amp   [NCH];
  logic [OUT_W-1:0]    prod  [NCH];

  cwo_phase_gen #(.PHASE_W(PHASE_W), .IDX_W(IDX_W)) u_phase (
    .clk_i, .rst_ni,
    .step_i     (valid_i),
    .fcw_i,
    .trim_i     (perr_i),
    .trim_load_i(perr_load_i),
    .idx_o      (idx)
  );

  cwo_sincos_lut u_lut (.idx_i(idx), .cos_o(cos_v), .sin_o(sin_v));

  assign smp_d[0] = i_i;
  assign smp_d[1] = q_i;
  assign amp[0]   = cos_v;
  assign amp[1]   = sin_v;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v1_q    <= 1'b0;
      valid_o <= 1'b0;
    end else begin
      v1_q    <= valid_i;
      valid_o <= v1_q;
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      smp_q[c] <= '0;
      else if (valid_i) smp_q[c] <= smp_d[c];
    end

    cwo_scale #(.IN_W(SAMPLE_W), .AMP_W(AMP_W)) u_scale (
      .clk_i, .rst_ni,
      .en_i (v1_q),
      .x_i  (smp_q[c]),
      .amp_i(amp[c]),
      .y_o  (prod[c])
    );
  end

  assign i_o = prod[0];
  assign q_o = prod[1];
endmodule

// File: rtl/cwo_mixer_chk.sv
module cwo_mixer_chk #(
  parameter int SAMPLE_W = 3,
  parameter int OUT_W    = 6
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                valid_i,
  input logic [SAMPLE_W-1:0] i_i,
  input logic                valid_o,
  input logic [OUT_W-1:0]    i_o,
  input logic [OUT_W-1:0]    q_o
);
  localparam int LIM = (2 ** (SAMPLE_W - 1)) * 3;

  logic [1:0] cyc_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cyc_q <= '0;
    else if (cyc_q != 2'd3) cyc_q <= cyc_q + 2'd1;
  end

  always @(posedge clk_i) begin
    if (!rst_ni) a_r1_reset_quiet: assert (valid_o == 1'b0 && i_o == '0 && q_o == '0);
  end

  a_r2_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q >= 2'd2) |-> (valid_o == $past(valid_i, 2)));

  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q >= 2'd1 && !valid_o) |-> ($stable(i_o) && $stable(q_o)));

  a_r5_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ($signed(i_o) <= LIM && $signed(i_o) >= -LIM &&
                 $signed(q_o) <= LIM && $signed(q_o) >= -LIM));

  a_r5_zero_in: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q >= 2'd2 && valid_o && $past(i_i, 2) == '0 && $past(valid_i, 2)) |-> (i_o == '0));
endmodule

bind cwo_mixer cwo_mixer_chk #(.SAMPLE_W(SAMPLE_W), .OUT_W(OUT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .i_i(i_i),
  .valid_o(valid_o), .i_o(i_o), .q_o(q_o)
);

// File: tb/tb_cwo_mixer.sv
module tb_cwo_mixer;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [2:0]  i_i = '0, q_i = '0;
  logic [31:0] fcw_i = '0, perr_i = '0;
  logic        perr_load_i = 1'b0;
  logic        valid_o;
  logic [5:0]  i_o, q_o;

  int total = 0, bad = 0;
  bit done = 0;

  // bench model state
  int unsigned m_acc, m_trim;
  bit          m_v1, e_v;
  logic [2:0]  m_idx;
  logic signed [2:0] m_i, m_q;
  logic signed [5:0] e_i, e_q;

  always #10 clk_i = ~clk_i;

  cwo_mixer dut (.*);

  function automatic int cos_ref(input int k);
    int t[8] = '{3, 2, 0, -2, -3, -2, 0, 2};
    return t[k & 7];
  endfunction

  function automatic int sin_ref(input int k);
    return cos_ref(k + 6);
  endfunction

  task automatic chk(input string tag, input int act, input int exp, input string what);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_acc = 0; m_trim = 0; m_v1 = 0; e_v = 0;
    m_idx = 0; m_i = 0; m_q = 0; e_i = 0; e_q = 0;
  endtask

  task automatic compare(input string tag);
    chk(tag, valid_o, e_v, "valid_o");
    chk(tag, $signed(i_o), e_i, "i_o");
    chk(tag, $signed(q_o), e_q, "q_o");
  endtask

  task automatic step(input bit v, input int si, input int sq, input int unsigned f,
                      input int unsigned pe, input bit ld, input string tag);
    int unsigned ph;
    valid_i = v; i_i = 3'(si); q_i = 3'(sq); fcw_i = f; perr_i = pe; perr_load_i = ld;
    @(posedge clk_i);
    if (m_v1) begin
      e_i = 6'(int'(m_i) * cos_ref(m_idx));
      e_q = 6'(int'(m_q) * sin_ref(m_idx));
    end
    e_v = m_v1;
    m_v1 = v;
    if (v) begin
      ph = m_acc + m_trim;
      m_idx = ph[31:29];
      m_i = 3'(si); m_q = 3'(sq);
      m_acc = m_acc + f;
    end
    if (ld) m_trim = pe;
    @(negedge clk_i);
    compare(tag);
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; valid_i = 0; perr_load_i = 0;
    model_reset();
    repeat (2) @(negedge clk_i);
    compare("R1");
    rst_ni = 1'b1;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    do_reset();
    // R1: first sample after reset uses phase 0 -> cos 3, sin 0
    step(1, 1, 1, 32'h1234_5678, 0, 0, "R1");
    step(0, 0, 0, 0, 0, 0, "R1");
    step(0, 0, 0, 0, 0, 0, "R1");
    chk("R1", $signed(i_o), 3, "first i_o");
    chk("R1", $signed(q_o), 0, "first q_o");

    // R4: one table index per sample, walk all entries
    do_reset();
    for (int k = 0; k < 10; k++) step(1, 1, 1, 32'h2000_0000, 0, 0, "R4");
    // R5: extreme sample values
    for (int k = 0; k < 8; k++) step(1, -4, -4, 32'h2000_0000, 0, 0, "R5");
    for (int k = 0; k < 8; k++) step(1, 3, -3, 32'h2000_0000, 0, 0, "R5");

    // R3: idle cycles with large fcw must not advance phase
    for (int k = 0; k < 6; k++) begin
      step(1, 2, 2, 32'h2000_0000, 0, 0, "R3");
      step(0, 0, 0, 32'h6000_0000, 0, 0, "R3");
      step(0, 0, 0, 32'hF000_0000, 0, 0, "R3");
    end

    // R8: outputs hold during idle stretch
    step(1, 3, 3, 0, 0, 0, "R8");
    for (int k = 0; k < 8; k++) step(0, -1, 1, 32'h1000_0000, 0, 0, "R8");

    // R7: perr_i toggling without load
    for (int k = 0; k < 6; k++) step(1, 1, 1, 32'h2000_0000, 32'h8000_0000 + k, 0, "R7");

    // R6: load on same edge as a sample, then following samples
    step(1, 1, 1, 0, 32'h4000_0000, 1, "R6");
    for (int k = 0; k < 4; k++) step(1, 1, 1, 0, 0, 0, "R6");
    step(0, 0, 0, 0, 32'hC000_0000, 1, "R6");
    for (int k = 0; k < 4; k++) step(1, -2, 2, 0, 0, 0, "R6");

    // R2: mixed valid patterns, random stimulus
    begin
      int unsigned f = $urandom;
      for (int n = 0; n < 3000; n++) begin
        bit v = ($urandom % 6) < 2;
        if ($urandom % 50 == 0) f = $urandom;
        step(v, int'($urandom % 8) - 4, int'($urandom % 8) - 4, f,
             $urandom, ($urandom % 20) == 0, "R2");
      end
    end

    // R1: reset mid-run
    step(1, 3, 3, 32'h3000_0000, 0, 0, "R1");
    do_reset();
    step(0, 0, 0, 0, 0, 0, "R1");
    step(1, -3, 2, 32'h7000_0000, 0, 0, "R1");
    step(0, 0, 0, 0, 0, 0, "R1");
    step(0, 0, 0, 0, 0, 0, "R1");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule